// File: doc/BRIEF.md
# Fixed-Point Recursive Low-Pass Smoother

This block is a single-pole recursive (IIR) low-pass filter for unsigned 12-bit samples. Each time a sample strobe arrives, it forms a new output from a weighted sum of the incoming sample and the output it produced last time. Both weights are unsigned fixed-point values with 12 fractional bits. The sum of the two products is held in a 32-bit accumulator. It is then truncated back to 12 integer bits, and that result becomes both the new output and the feedback state.

A periodic tick normally drives the strobe, and the tick rate sets the time scale. The time constant is a count of samples, so the cutoff frequency moves in proportion to the strobe rate. The default weights, 482 and 3614, add up to 4096. This gives unity gain at DC, apart from the loss to truncation. With these weights, a full-scale step passes about 63% of its final value roughly 8 samples after it is applied. Every sample takes exactly one clock, whatever the operand values.

Top module: `iir_lp_filter`

## Requirements
- R1: When synchronous active-high reset `rst` is asserted, the next clock edge clears the state, `y_out` and `y_vld` to 0.
- R2: A clock edge with `x_vld` high sets `y_out` to floor((C_IN*x_in + C_FB*y_prev)/4096). Here y_prev is the previous `y_out`, C_IN defaults to 482 and C_FB defaults to 3614.
- R3: `y_vld` is high for exactly the one cycle after each edge on which `x_vld` was high, and low otherwise.
- R4: While `x_vld` is low, `y_out` and the state keep their values.
- R5: The accumulator is 32 bits wide and never overflows. The result always fits in 12 bits, because C_IN + C_FB = 4096 is checked when the module elaborates.
- R6: A constant input of 0 held from reset gives an output of 0. A constant input of 4095 rises monotonically and never exceeds 4095.
- R7: With the default weights, a step from 0 to 4095 gives outputs that match the integer recursion exactly, sample by sample. The output reaches at least 63% of full scale (2580) within 9 samples and has not reached it after 7 samples.
- R8: Every sample takes exactly one clock cycle, for any operand values. A strobe on every cycle is accepted and produces one result per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_vld | input | 1 | Sample strobe; one sample accepted per high cycle |
| x_in | input | 12 | Unsigned input sample |
| y_out | output | 12 | Registered filtered output |
| y_vld | output | 1 | One-cycle pulse marking a new output |

## Verification
Every result is due one clock edge after the strobe that produced it.
- Both `y_out` and `y_vld` come from registers loaded on the edge at which `x_vld` is sampled high.
- The bench drives each strobe for one cycle and reads the outputs at the following falling edge.
- There it compares `y_out` with an integer model of the recursion and checks that `y_vld` is high.

A cycle later it checks that `y_vld` has dropped and that `y_out` has not moved. Strobes on back-to-back cycles are checked edge by edge in the same way.

// File: rtl/iir_lp_pkg.sv
package iir_lp_pkg;
    localparam int SAMPLE_W = 12;
    localparam int FRAC_W   = 12;
    localparam int COEF_W   = 13;
    localparam int ACC_W    = 32;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [ACC_W-1:0]    acc_t;

    typedef struct packed {
        sample_t y;
        logic    vld;
    } filt_state_t;
endpackage

// File: rtl/iir_lp_mac.sv
module iir_lp_mac
    import iir_lp_pkg::*;
#(
    parameter int C_IN = 482,
    parameter int C_FB = 3614
) (
    input  sample_t x,
    input  sample_t y_prev,
    output sample_t y_next
);
    localparam acc_t K_IN = acc_t'(C_IN);
    localparam acc_t K_FB = acc_t'(C_FB);

    acc_t prod_in;
    acc_t prod_fb;
    acc_t acc;

    always_comb begin
        prod_in = K_IN * acc_t'(x);
        prod_fb = K_FB * acc_t'(y_prev);
        acc     = prod_in + prod_fb;
    end

    // The weights sum to 2^FRAC_W, so the upper accumulator bits stay zero.
    assign y_next = acc[FRAC_W +: SAMPLE_W];

    always_comb begin
        a_r5_no_overflow: assert (acc[ACC_W-1:FRAC_W+SAMPLE_W] == '0);
    end
endmodule

// File: rtl/iir_lp_filter.sv
module iir_lp_filter
    import iir_lp_pkg::*;
#(
    parameter int C_IN = 482,
    parameter int C_FB = 3614
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        x_vld,
    input  logic [11:0] x_in,
    output logic [11:0] y_out,
    output logic        y_vld
);
    localparam int UNITY = 1 << FRAC_W;

    generate
        if (C_IN + C_FB != UNITY || C_IN < 0 || C_FB < 0) begin : g_bad_coef
            $error("iir_lp_filter: weights must be non-negative and sum to 4096");
        end
    endgenerate

    filt_state_t st_d, st_q;
    sample_t     y_calc;

    iir_lp_mac #(.C_IN(C_IN), .C_FB(C_FB)) u_mac (
        .x      (x_in),
        .y_prev (st_q.y),
        .y_next (y_calc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = x_vld;
        if (x_vld) begin
            st_d.y = y_calc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out = st_q.y;
    assign y_vld = st_q.vld;

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (y_out == '0 && !y_vld));

    a_r3_vld_follows: assert property (@(posedge clk) disable iff (rst)
        x_vld |=> y_vld);

    a_r3_vld_drops: assert property (@(posedge clk) disable iff (rst)
        !x_vld |=> !y_vld);

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !x_vld) |=> $stable(y_out));

    a_r6_toward_input: assert property (@(posedge clk) disable iff (rst)
        (past_ok && x_vld && x_in >= y_out) |=> (y_out >= $past(y_out) && y_out <= $past(x_in)));
endmodule

// File: tb/tb_iir_lp_filter.sv
module tb_iir_lp_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        x_vld;
    logic [11:0] x_in;
    logic [11:0] y_out;
    logic        y_vld;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit timed_out = 0;

    always #10 clk = ~clk;

    iir_lp_filter dut (
        .clk(clk), .rst(rst), .x_vld(x_vld), .x_in(x_in),
        .y_out(y_out), .y_vld(y_vld)
    );

    function automatic int ref_step(int x, int yp);
        return (482 * x + 3614 * yp) >>> 12;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; x_vld = 1'b0; x_in = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = 0;
    endtask

    // one strobe; sample the outputs at the next falling edge
    task automatic push(int x, string req);
        x_in = 12'(x); x_vld = 1'b1;
        @(negedge clk);
        x_vld = 1'b0;
        model = ref_step(x, model);
        check(req, int'(y_out), model);
        check("R3", int'(y_vld), 1);
    endtask

    task automatic t_reset();
        push(4095, "R2");
        push(4095, "R2");
        rst = 1'b1;
        @(negedge clk);
        check("R1 y_out", int'(y_out), 0);
        check("R1 y_vld", int'(y_vld), 0);
        rst = 1'b0;
        model = 0;
    endtask

    task automatic t_zero();
        for (int i = 0; i < 20; i++) push(0, "R6");
        check("R6 zero", int'(y_out), 0);
    endtask

    task automatic t_step();
        int prev;
        prev = 0;
        for (int i = 1; i <= 120; i++) begin
            push(4095, "R7");
            if (i == 7) check("R7 below 63% at 7", int'(y_out < 12'd2580), 1);
            if (i == 9) check("R7 63% by 9", int'(y_out >= 12'd2580), 1);
            check("R6 monotonic", int'(int'(y_out) >= prev && y_out <= 12'd4095), 1);
            prev = int'(y_out);
        end
    endtask

    task automatic t_hold();
        int keep;
        keep = int'(y_out);
        x_in = 12'd0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R4 hold", int'(y_out), keep);
            check("R3 idle", int'(y_vld), 0);
        end
    endtask

    task automatic t_fall_gapped();
        for (int i = 0; i < 30; i++) begin
            push(0, "R2");
            @(negedge clk);
            check("R3 one-cycle", int'(y_vld), 0);
            check("R4", int'(y_out), model);
        end
    endtask

    task automatic t_mixed();
        int xs[8] = '{1000, 3000, 17, 4095, 2048, 0, 777, 4000};
        for (int i = 0; i < 40; i++) push(xs[i % 8], "R8");
    endtask

    initial begin
        fork
            begin
                do_reset();
                check("R1 reset y_out", int'(y_out), 0);
                check("R1 reset y_vld", int'(y_vld), 0);
                t_reset();
                t_zero();
                t_step();
                t_hold();
                t_fall_gapped();
                t_mixed();
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule